// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block turns a bank of wired interrupt inputs into message-signalled interrupts. Each input line owns one redirection entry. The entry holds the vector value that is placed in the message, the destination processor identifiers that form the message address, the input polarity, the trigger mode and a mask bit. When an unmasked line becomes active, the block issues one message write on a valid/ready output. Edge-triggered lines send one message per active edge. Level-triggered lines send one message and then wait for an end-of-interrupt before they can send again.

Software reaches the entries through a small register port. It writes an index into a select register and then reads or writes the selected register through a data window. Each entry takes two consecutive 32-bit words. A separate end-of-interrupt offset takes the vector value of the interrupt being completed. That write re-arms every level-triggered entry with the same vector, so a line that is still asserted sends its message again. Register reads are combinational from the current select value.

Top module: `line_msg_redirect`

## Requirements
- R1: After reset, msg_valid is 0, every entry low word reads 0x00010000 (masked, all other fields zero) and every entry high word reads 0.
- R2: Window index 0x01 is read-only. It returns the version parameter in bits 7:0 and NUM_LINES-1 in bits 23:16, with all other bits zero. Writes to it are ignored.
- R3: Offset 0x00 holds the select index and reads it back in bits 7:0. Offset 0x10 accesses the selected register. Entry n has its low word at index 0x10+2n and its high word at index 0x11+2n. The low word holds: mask in bit 16, level trigger in bit 15, active-low polarity in bit 13, vector in bits 7:0. All other low-word bits read as zero.
- R4: The high word holds the destination id in bits 31:24 and the extended id in bits 23:16, with bits 15:0 reading zero. Writing the high word leaves the low word unchanged.
- R5: A window index other than 0x01 and the implemented entry words reads zero, and writes to it change nothing. Any reg_addr other than 0x00 and 0x10 reads zero.
- R6: Each message carries msg_addr = {id, extended id, 16'h0} and msg_data = the entry vector in bits 7:0, with bits 31:8 zero.
- R7: An edge-triggered, unmasked entry sends exactly one message per inactive-to-active transition. Holding the input active sends nothing more.
- R8: A level-triggered, unmasked entry sends one message while its input is active and no more until an end-of-interrupt arrives. An end-of-interrupt (a write to offset 0x40 with the vector in bits 7:0) re-sends the message if and only if the input is still active. A non-matching vector has no effect.
- R9: A masked entry sends no message.
- R10: When several entries are pending, the lowest-numbered entry is sent first, and only one message is outstanding at a time.
- R11: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data stay unchanged.
- R12: With active-low polarity, a falling input edge counts as activation and a rising edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Wired interrupt inputs, one per entry |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset (0x00 select, 0x10 window, 0x40 end-of-interrupt) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| msg_valid | output | 1 | Message write is offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 32 | Message data (vector) |

## Verification
Assertions check four things on every cycle: that a stalled message stays stable, that message address and data keep their zero fields, that unmapped offsets read zero, and that the arbiter grants at most one line and only into an empty output slot. Other behaviour depends on history that only the bench's scenarios can set up. This covers one message per edge versus one message per end-of-interrupt, the lowest-first ordering of simultaneous requests, masking, polarity inversion, and the rule that a destination update leaves the mode bits alone. Random programming of vectors and destinations on random lines is mixed with directed cases for each of these.

// File: rtl/lmi_pkg.sv
package lmi_pkg;

    localparam int VEC_W     = 8;
    localparam int MASK_POS  = 16;
    localparam int LEVEL_POS = 15;
    localparam int POL_POS   = 13;
    localparam int ID_LSB    = 24;
    localparam int EID_LSB   = 16;

    localparam logic [7:0] OFF_SELECT  = 8'h00;
    localparam logic [7:0] OFF_WINDOW  = 8'h10;
    localparam logic [7:0] OFF_EOI     = 8'h40;
    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam int         IDX_BASE    = 16;

    typedef struct packed {
        logic             mask;
        logic             level;
        logic             pol_low;
        logic [VEC_W-1:0] vec;
        logic [7:0]       dest_id;
        logic [7:0]       dest_eid;
    } lmi_entry_t;

    localparam lmi_entry_t ENTRY_RESET = '{mask: 1'b1, default: '0};

    function automatic logic [31:0] pack_low(lmi_entry_t e);
        logic [31:0] w;
        w              = '0;
        w[MASK_POS]    = e.mask;
        w[LEVEL_POS]   = e.level;
        w[POL_POS]     = e.pol_low;
        w[VEC_W-1:0]   = e.vec;
        return w;
    endfunction

    function automatic logic [31:0] pack_high(lmi_entry_t e);
        return {e.dest_id, e.dest_eid, 16'h0000};
    endfunction

endpackage

// File: rtl/lmi_line.sv
module lmi_line (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic mask_i,
    input  logic level_i,
    input  logic pol_low_i,
    input  logic eoi_hit_i,
    input  logic grant_i,
    output logic req_o
);

    typedef struct packed {
        logic act_prev;
        logic pend;
        logic insvc;
    } line_state_t;

    line_state_t s_q, s_d;
    logic        active;

    always_comb begin
        s_d    = s_q;
        active = irq_i ^ pol_low_i;

        s_d.act_prev = active;

        if (eoi_hit_i) begin
            s_d.insvc = 1'b0;
        end

        if (grant_i) begin
            s_d.pend = 1'b0;
            if (level_i) begin
                s_d.insvc = 1'b1;
            end
        end

        if (level_i) begin
            if (!active) begin
                s_d.pend = 1'b0;
            end else if (!mask_i && !s_q.insvc && !s_q.pend && !grant_i) begin
                s_d.pend = 1'b1;
            end
        end else if (!mask_i && active && !s_q.act_prev) begin
            s_d.pend = 1'b1;
        end

        req_o = s_q.pend && !mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/lmi_pick.sv
module lmi_pick #(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0] req_i,
    input  logic                 enable_i,
    output logic [NUM_LINES-1:0] grant_o,
    output logic                 any_o
);

    logic [NUM_LINES:0] blocked;

    assign blocked[0] = ~enable_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chain
        assign grant_o[g]   = req_i[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | req_i[g];
    end

    assign any_o = |grant_o;

endmodule

// File: rtl/lmi_regs.sv
module lmi_regs
    import lmi_pkg::*;
#(
    parameter int         NUM_LINES = 8,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [7:0]                       addr,
    input  logic [31:0]                      wdata,
    output logic [31:0]                      rdata,
    output lmi_entry_t [NUM_LINES-1:0]       entries_o,
    output logic                             eoi_valid_o,
    output logic [VEC_W-1:0]                 eoi_vec_o
);

    localparam logic [7:0] MAX_ENTRY = 8'(NUM_LINES - 1);

    typedef struct packed {
        logic [7:0]                  sel;
        lmi_entry_t [NUM_LINES-1:0]  ent;
    } regs_state_t;

    regs_state_t          s_q, s_d;
    logic [NUM_LINES-1:0] lo_hit;
    logic [NUM_LINES-1:0] hi_hit;
    logic [31:0]          win_rd;
    logic                 unused_wdata;

    assign unused_wdata = ^{wdata[14], wdata[12:VEC_W]};

    always_comb begin
        s_d    = s_q;
        win_rd = '0;

        for (int i = 0; i < NUM_LINES; i++) begin
            lo_hit[i] = (s_q.sel == 8'(IDX_BASE + 2 * i));
            hi_hit[i] = (s_q.sel == 8'(IDX_BASE + 2 * i + 1));
        end

        if (s_q.sel == IDX_VERSION) begin
            win_rd = {8'h00, MAX_ENTRY, 8'h00, VERSION};
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            if (lo_hit[i]) win_rd = pack_low(s_q.ent[i]);
            if (hi_hit[i]) win_rd = pack_high(s_q.ent[i]);
        end

        case (addr)
            OFF_SELECT: rdata = {24'h0, s_q.sel};
            OFF_WINDOW: rdata = win_rd;
            default:    rdata = '0;
        endcase

        if (wr_en && addr == OFF_SELECT) begin
            s_d.sel = wdata[7:0];
        end

        if (wr_en && addr == OFF_WINDOW) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (lo_hit[i]) begin
                    s_d.ent[i].mask    = wdata[MASK_POS];
                    s_d.ent[i].level   = wdata[LEVEL_POS];
                    s_d.ent[i].pol_low = wdata[POL_POS];
                    s_d.ent[i].vec     = wdata[VEC_W-1:0];
                end
                if (hi_hit[i]) begin
                    s_d.ent[i].dest_id  = wdata[ID_LSB +: 8];
                    s_d.ent[i].dest_eid = wdata[EID_LSB +: 8];
                end
            end
        end

        eoi_valid_o = wr_en && (addr == OFF_EOI);
        eoi_vec_o   = wdata[VEC_W-1:0];
        entries_o   = s_q.ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sel <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                s_q.ent[i] <= ENTRY_RESET;
            end
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/line_msg_redirect.sv
module line_msg_redirect
    import lmi_pkg::*;
#(
    parameter int         NUM_LINES = 8,
    parameter logic [7:0] VERSION   = 8'h21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_wr_en,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);

    typedef struct packed {
        logic        valid;
        logic [31:0] addr;
        logic [31:0] data;
    } out_state_t;

    out_state_t                 o_q, o_d;
    lmi_entry_t [NUM_LINES-1:0] entries;
    logic                       eoi_valid;
    logic [VEC_W-1:0]           eoi_vec;
    logic [NUM_LINES-1:0]       line_req;
    logic [NUM_LINES-1:0]       line_grant;
    logic                       any_grant;
    lmi_entry_t                 chosen;

    lmi_regs #(
        .NUM_LINES (NUM_LINES),
        .VERSION   (VERSION)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .entries_o   (entries),
        .eoi_valid_o (eoi_valid),
        .eoi_vec_o   (eoi_vec)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        lmi_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_i     (irq_lines[g]),
            .mask_i    (entries[g].mask),
            .level_i   (entries[g].level),
            .pol_low_i (entries[g].pol_low),
            .eoi_hit_i (eoi_valid && (entries[g].vec == eoi_vec)),
            .grant_i   (line_grant[g]),
            .req_o     (line_req[g])
        );
    end

    lmi_pick #(
        .NUM_LINES (NUM_LINES)
    ) u_pick (
        .req_i    (line_req),
        .enable_i (!o_q.valid),
        .grant_o  (line_grant),
        .any_o    (any_grant)
    );

    always_comb begin
        o_d    = o_q;
        chosen = '0;

        for (int i = 0; i < NUM_LINES; i++) begin
            if (line_grant[i]) chosen = chosen | entries[i];
        end

        if (o_q.valid && msg_ready) begin
            o_d.valid = 1'b0;
        end

        if (any_grant) begin
            o_d.valid = 1'b1;
            o_d.addr  = {chosen.dest_id, chosen.dest_eid, 16'h0000};
            o_d.data  = {{(32 - VEC_W){1'b0}}, chosen.vec};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign msg_valid = o_q.valid;
    assign msg_addr  = o_q.addr;
    assign msg_data  = o_q.data;

endmodule

// File: rtl/lmi_checker.sv
module lmi_checker
    import lmi_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           reg_addr,
    input logic [31:0]          reg_rdata,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic [31:0]          msg_addr,
    input logic [31:0]          msg_data,
    input logic [NUM_LINES-1:0] grant
);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    a_r6_addr_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[15:0] == 16'h0000);

    a_r6_data_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_data[31:VEC_W] == '0);

    a_r5_unmapped_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFF_SELECT && reg_addr != OFF_WINDOW) |-> reg_rdata == 32'h0);

    a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r10_grant_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> !msg_valid);

    a_r10_grant_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> msg_valid);

endmodule

bind line_msg_redirect lmi_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .grant     (line_grant)
);

// File: tb/line_msg_redirect_bench.sv
module line_msg_redirect_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         N          = 8;
    localparam logic [7:0] VER        = 8'h21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_lines = '0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_msg_redirect #(.NUM_LINES(N), .VERSION(VER)) u_line_msg_redirect (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    function automatic logic [31:0] exp_low(bit mask, bit level, bit pol, logic [7:0] vec);
        return (32'(mask) << 16) | (32'(level) << 15) | (32'(pol) << 13) | 32'(vec);
    endfunction

    function automatic logic [31:0] exp_high(logic [7:0] id, logic [7:0] eid);
        return {id, eid, 16'h0000};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_addr  = 8'h00;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic win_write(logic [7:0] idx, logic [31:0] d);
        reg_write(8'h00, {24'h0, idx});
        reg_write(8'h10, d);
    endtask

    task automatic win_read(logic [7:0] idx, output logic [31:0] d);
        reg_write(8'h00, {24'h0, idx});
        reg_read(8'h10, d);
    endtask

    task automatic wait_msg(string tag, logic [31:0] ea, logic [31:0] ed);
        int n;
        n = 0;
        @(negedge clk);
        while (!msg_valid && n < 30) begin
            @(negedge clk);
            n++;
        end
        if (!msg_valid) begin
            checks++;
            errors++;
            $display("FAIL %s actual=no message expected=addr %h data %h", tag, ea, ed);
        end else begin
            chk({tag, " addr"}, msg_addr, ea);
            chk({tag, " data"}, msg_data, ed);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    task automatic expect_none(string tag, int cycles);
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        chk(tag, 32'(seen), 32'd0);
        if (seen) begin
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240607));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 msg_valid", 32'(msg_valid), 32'd0);
        win_read(8'h10, rd);                 chk("R1 low 0", rd, 32'h0001_0000);
        win_read(8'(16 + 2 * (N - 1)), rd);  chk("R1 low last", rd, 32'h0001_0000);
        win_read(8'(17 + 2 * (N - 1)), rd);  chk("R1 high last", rd, 32'h0);

        // R2 version register, read-only
        win_read(8'h01, rd);
        chk("R2 version", rd, {8'h00, 8'(N - 1), 8'h00, VER});
        win_write(8'h01, 32'hFFFF_FFFF);
        win_read(8'h01, rd);
        chk("R2 version write ignored", rd, {8'h00, 8'(N - 1), 8'h00, VER});

        // R3 select readback and low-word layout
        reg_write(8'h00, 32'h14);
        reg_read(8'h00, rd);                 chk("R3 select readback", rd, 32'h14);
        win_write(8'h14, 32'hFFFF_A05A & exp_low(0, 0, 0, 8'h5A) | 32'h0000_5F00);
        win_read(8'h14, rd);                 chk("R3 low fields", rd, exp_low(0, 0, 0, 8'h5A));

        // R4 high word write leaves low word alone
        win_write(8'h15, 32'hABCD_FFFF);
        win_read(8'h15, rd);                 chk("R4 high", rd, exp_high(8'hAB, 8'hCD));
        win_read(8'h14, rd);                 chk("R4 low unchanged", rd, exp_low(0, 0, 0, 8'h5A));

        // R7/R6 edge trigger on line 2
        @(negedge clk); irq_lines[2] = 1'b1;
        wait_msg("R7 R6 edge msg", exp_high(8'hAB, 8'hCD), 32'h5A);
        expect_none("R7 held high no repeat", 12);
        @(negedge clk); irq_lines[2] = 1'b0;
        expect_none("R7 falling edge no msg", 6);

        // R11 stall holds the message stable
        @(negedge clk); irq_lines[2] = 1'b1;
        begin
            int n;
            n = 0;
            while (!msg_valid && n < 30) begin @(negedge clk); n++; end
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                chk("R11 stall valid", 32'(msg_valid), 32'd1);
                chk("R11 stall data", msg_data, 32'h5A);
            end
            chk("R11 stall addr", msg_addr, exp_high(8'hAB, 8'hCD));
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
        @(negedge clk); irq_lines[2] = 1'b0;

        // R9 masked entry sends nothing
        win_write(8'h17, exp_high(8'h11, 8'h22));
        win_write(8'h16, exp_low(1, 0, 0, 8'h77));
        @(negedge clk); irq_lines[3] = 1'b1;
        expect_none("R9 masked edge", 10);
        @(negedge clk); irq_lines[3] = 1'b0;

        // R8 level trigger and end-of-interrupt
        win_write(8'h19, exp_high(8'h40, 8'h04));
        win_write(8'h18, exp_low(0, 1, 0, 8'h33));
        @(negedge clk); irq_lines[4] = 1'b1;
        wait_msg("R8 level first", exp_high(8'h40, 8'h04), 32'h33);
        expect_none("R8 no repeat before eoi", 12);
        reg_write(8'h40, 32'h34);
        expect_none("R8 wrong vector eoi", 10);
        reg_write(8'h40, 32'h33);
        wait_msg("R8 eoi resend", exp_high(8'h40, 8'h04), 32'h33);
        @(negedge clk); irq_lines[4] = 1'b0;
        reg_write(8'h40, 32'h33);
        expect_none("R8 eoi with line low", 10);

        // R12 active-low edge on line 5
        @(negedge clk); irq_lines[5] = 1'b1;
        win_write(8'h1B, exp_high(8'h55, 8'h66));
        win_write(8'h1A, exp_low(0, 0, 1, 8'hC5));
        expect_none("R12 setup quiet", 4);
        @(negedge clk); irq_lines[5] = 1'b0;
        wait_msg("R12 falling edge", exp_high(8'h55, 8'h66), 32'hC5);
        @(negedge clk); irq_lines[5] = 1'b1;
        expect_none("R12 rising edge ignored", 10);

        // R10 lowest entry first
        win_write(8'h11, exp_high(8'h01, 8'h00));
        win_write(8'h10, exp_low(0, 0, 0, 8'h10));
        win_write(8'h13, exp_high(8'h02, 8'h00));
        win_write(8'h12, exp_low(0, 0, 0, 8'h11));
        win_write(8'h1D, exp_high(8'h07, 8'h00));
        win_write(8'h1C, exp_low(0, 0, 0, 8'h16));
        @(negedge clk); irq_lines[6] = 1'b1; irq_lines[1] = 1'b1; irq_lines[0] = 1'b1;
        wait_msg("R10 first line0", exp_high(8'h01, 8'h00), 32'h10);
        wait_msg("R10 second line1", exp_high(8'h02, 8'h00), 32'h11);
        wait_msg("R10 third line6", exp_high(8'h07, 8'h00), 32'h16);
        expect_none("R10 no extra", 6);

        // R5 unmapped index and offsets
        win_write(8'(16 + 2 * N), 32'hFFFF_FFFF);
        win_read(8'(16 + 2 * N), rd);        chk("R5 past last entry", rd, 32'h0);
        win_read(8'(15 + 2 * N), rd);        chk("R5 neighbour untouched", rd, 32'h0);
        win_read(8'h02, rd);                 chk("R5 index 2", rd, 32'h0);
        reg_read(8'h20, rd);                 chk("R5 offset 0x20", rd, 32'h0);

        // quiesce: mask all, drop all lines
        for (int i = 0; i < N; i++) win_write(8'(16 + 2 * i), exp_low(1, 0, 0, 8'h00));
        @(negedge clk); irq_lines = '0;
        expect_none("R9 all masked quiet", 4);

        // random programming of edge entries (R3 R6 R7)
        for (int it = 0; it < 40; it++) begin
            int         ln;
            logic [7:0] v, id, eid;
            ln  = $urandom_range(0, N - 1);
            v   = 8'($urandom_range(0, 255));
            id  = 8'($urandom_range(0, 255));
            eid = 8'($urandom_range(0, 255));
            win_write(8'(17 + 2 * ln), exp_high(id, eid));
            win_write(8'(16 + 2 * ln), exp_low(0, 0, 0, v));
            win_read(8'(16 + 2 * ln), rd);
            chk("R3 random low readback", rd, exp_low(0, 0, 0, v));
            @(negedge clk); irq_lines[ln] = 1'b1;
            wait_msg("R6 random msg", exp_high(id, eid), 32'(v));
            @(negedge clk); irq_lines[ln] = 1'b0;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule